// File: doc/BRIEF.md
# Predicated Three-Way Deinterleaving Load Unit

This unit performs a contiguous structure load for a vector datapath. Memory holds records of three adjacent 64-bit words. On a start strobe the unit walks these records, reads them one word at a time through a simple request/response memory port, and scatters the words across three destination vectors. The first word of record i lands in lane i of destination 0, the second in lane i of destination 1 and the third in lane i of destination 2.

Each lane has a predicate bit. A record whose bit is clear is skipped entirely: its words are never requested, it can never produce a fault, and its lane reads as zero in all three destinations. The effective base address is a base operand plus an index operand counted in 64-bit words. A memory error response ends the operation early and reports which lane faulted. The vector length is a parameter from 128 to 2048 bits, giving 2 to 32 lanes.

Top module: `trio_split_loader`

## Requirements
- R1: The effective base is `base_i + 8*index_i`, computed modulo 2^ADDR_W; the index counts 64-bit words.
- R2: Word j (0, 1, 2) of record i is read from effective base + 24*i + 8*j. When `done_o` pulses, lane i (bits 64*i+63 down to 64*i) of destination j holds that word.
- R3: Reads go out in ascending lane order and, within a lane, in ascending word order. At most one read is outstanding, and a pending request keeps its address stable until `mem_req_ready_i` is high.
- R4: No read is issued for a lane whose predicate bit is clear, so an error at such an address can never cause a fault.
- R5: A lane whose predicate bit is clear reads as zero in all three destinations at `done_o`, even when an earlier operation wrote it.
- R6: `done_o` is a one-cycle pulse. It comes in the cycle after the edge that accepts the last response, or in the cycle after the start edge when every predicate bit is clear.
- R7: An error response (`mem_rsp_err_i` high with `mem_rsp_valid_i`) ends the operation. `fault_o` pulses for one cycle and `fault_elem_o` holds the lane of the faulting read. No further request follows, and `done_o` does not pulse.
- R8: A start strobe is ignored while an operation is in progress. This holds in the cycle of the final response as well.
- R9: After `done_o` or `fault_o` the unit is idle and accepts the next start strobe.
- R10: After reset no request is pending, `done_o` and `fault_o` are low, and all destinations are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| base_i | input | ADDR_W | Base byte address |
| index_i | input | ADDR_W | Index in 64-bit words |
| pred_i | input | VLEN/64 | Lane predicate mask |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | ADDR_W | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 64 | Read data |
| mem_rsp_err_i | input | 1 | Read response is an error |
| dst0_o | output | VLEN | Destination vector for word 0 of each record |
| dst1_o | output | VLEN | Destination vector for word 1 of each record |
| dst2_o | output | VLEN | Destination vector for word 2 of each record |
| done_o | output | 1 | Operation complete pulse |
| fault_o | output | 1 | Operation faulted pulse |
| fault_elem_o | output | log2(VLEN/64) | Lane of the faulting read |

## Verification
Two events can fall in the same cycle: a new start strobe and acceptance of the final response of the running operation. The bench provokes this by holding the strobe high from the second cycle of an operation until `done_o` is seen. During that time the strobe carries a different base and an all-ones mask. The collision is judged correct when the request log holds only the first operation's addresses, exactly one done pulse appears, and no request follows it. Separate runs cover a masked lane whose address would return an error, a stalled request port, and lanes left dirty by an earlier run.

// File: rtl/trio_pkg.sv
package trio_pkg;
    localparam int WORD_W    = 64;
    localparam int MAX_LANES = 32;
    localparam int LANE_IW   = 5;

    typedef logic [LANE_IW-1:0] lane_idx_t;
    typedef logic [1:0]         member_t;

    typedef struct packed {
        lane_idx_t lane;
        member_t   member;
    } cursor_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } trio_state_e;

    // Word offset of a cursor from the effective base: 3 words per record.
    function automatic logic [7:0] word_offset(input cursor_t c);
        return ({3'b000, c.lane} * 8'd3) + {6'b0, c.member};
    endfunction
endpackage

// File: rtl/trio_seek.sv
module trio_seek
    import trio_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [5:0]       from_i,
    output logic             found_o,
    output lane_idx_t        idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (mask_i[k] && (k >= int'(from_i))) begin
                found_o = 1'b1;
                idx_o   = lane_idx_t'(k);
            end
        end
    end
endmodule

// File: rtl/trio_addr_gen.sv
module trio_addr_gen
    import trio_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  cursor_t           cur_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [7:0] off;
    assign off    = word_offset(cur_i);
    assign addr_o = base_i + ADDR_W'({off, 3'b000});
endmodule

// File: rtl/trio_lanes.sv
module trio_lanes
    import trio_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IDX_W = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr_i,
    input  logic                          wr_i,
    input  cursor_t                       cur_i,
    input  logic [WORD_W-1:0]             data_i,
    output logic [2:0][LANES*WORD_W-1:0]  vecs_o
);
    for (genvar m = 0; m < 3; m++) begin : g_member
        logic [LANES-1:0][WORD_W-1:0] vec_q;

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                vec_q <= '0;
            end else if (wr_i && (cur_i.member == member_t'(m))) begin
                vec_q[cur_i.lane[IDX_W-1:0]] <= data_i;
            end
        end

        assign vecs_o[m] = vec_q;

        // R5: a clear leaves every lane of this destination at zero
        a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
            clr_i |=> (vecs_o[m] == '0));
    end
endmodule

// File: rtl/trio_ctrl.sv
module trio_ctrl
    import trio_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [LANES-1:0]  pred_i,
    input  logic              first_found_i,
    input  lane_idx_t         first_idx_i,
    input  logic              next_found_i,
    input  lane_idx_t         next_idx_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_err_i,
    output logic              req_valid_o,
    output cursor_t           cur_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [LANES-1:0]  pred_o,
    output logic              lane_clr_o,
    output logic              lane_wr_o,
    output logic              done_o,
    output logic              fault_o,
    output lane_idx_t         fault_lane_o
);
    trio_state_e       state_q;
    cursor_t           cur_q;
    logic [ADDR_W-1:0] base_q;
    logic [LANES-1:0]  pred_q;
    logic              done_q, fault_q;
    lane_idx_t         fault_lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cur_q        <= '0;
            base_q       <= '0;
            pred_q       <= '0;
            done_q       <= 1'b0;
            fault_q      <= 1'b0;
            fault_lane_q <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q <= base_i + {index_i[ADDR_W-4:0], 3'b000};
                        pred_q <= pred_i;
                        if (first_found_i) begin
                            cur_q   <= '{lane: first_idx_i, member: 2'd0};
                            state_q <= ST_REQ;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (req_ready_i) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rsp_valid_i) begin
                        if (rsp_err_i) begin
                            fault_q      <= 1'b1;
                            fault_lane_q <= cur_q.lane;
                            state_q      <= ST_IDLE;
                        end else if (cur_q.member != 2'd2) begin
                            cur_q.member <= cur_q.member + 2'd1;
                            state_q      <= ST_REQ;
                        end else if (next_found_i) begin
                            cur_q   <= '{lane: next_idx_i, member: 2'd0};
                            state_q <= ST_REQ;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_valid_o  = (state_q == ST_REQ);
    assign lane_clr_o   = (state_q == ST_IDLE) && start_i;
    assign lane_wr_o    = (state_q == ST_WAIT) && rsp_valid_i && !rsp_err_i;
    assign cur_o        = cur_q;
    assign base_o       = base_q;
    assign pred_o       = pred_q;
    assign done_o       = done_q;
    assign fault_o      = fault_q;
    assign fault_lane_o = fault_lane_q;

    // R3: a stalled request holds its cursor
    a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(cur_q)));
    // R4: only lanes with a set predicate are ever requested
    a_r4_active_only: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> pred_q[cur_q.lane[IDX_W-1:0]]);
    // R7: nothing is requested while a fault is reported, and done stays low
    a_r7_quiet_fault: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (!req_valid_o && !done_q));
    // R8: a strobe during a running operation leaves the latched operands alone
    a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q != ST_IDLE) |=> ($stable(base_q) && $stable(pred_q)));
endmodule

// File: rtl/trio_split_loader.sv
module trio_split_loader
    import trio_pkg::*;
#(
    parameter int VLEN   = 256,
    parameter int ADDR_W = 32,
    localparam int LANES = VLEN / WORD_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [LANES-1:0]  pred_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [WORD_W-1:0] mem_rsp_data_i,
    input  logic              mem_rsp_err_i,
    output logic [VLEN-1:0]   dst0_o,
    output logic [VLEN-1:0]   dst1_o,
    output logic [VLEN-1:0]   dst2_o,
    output logic              done_o,
    output logic              fault_o,
    output logic [IDX_W-1:0]  fault_elem_o
);
    logic              first_found, next_found;
    lane_idx_t         first_idx, next_idx, fault_lane;
    cursor_t           cur;
    logic [ADDR_W-1:0] base_eff;
    logic [LANES-1:0]  pred_q;
    logic              lane_clr, lane_wr;
    logic [5:0]        next_from;
    logic [2:0][VLEN-1:0] vecs;

    assign next_from = {1'b0, cur.lane} + 6'd1;

    trio_seek #(.LANES(LANES)) i_seek_first (
        .mask_i(pred_i), .from_i(6'd0), .found_o(first_found), .idx_o(first_idx));

    trio_seek #(.LANES(LANES)) i_seek_next (
        .mask_i(pred_q), .from_i(next_from), .found_o(next_found), .idx_o(next_idx));

    trio_ctrl #(.LANES(LANES), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .index_i(index_i), .pred_i(pred_i),
        .first_found_i(first_found), .first_idx_i(first_idx),
        .next_found_i(next_found), .next_idx_i(next_idx),
        .req_ready_i(mem_req_ready_i), .rsp_valid_i(mem_rsp_valid_i),
        .rsp_err_i(mem_rsp_err_i), .req_valid_o(mem_req_valid_o),
        .cur_o(cur), .base_o(base_eff), .pred_o(pred_q),
        .lane_clr_o(lane_clr), .lane_wr_o(lane_wr),
        .done_o(done_o), .fault_o(fault_o), .fault_lane_o(fault_lane));

    trio_addr_gen #(.ADDR_W(ADDR_W)) i_addr (
        .base_i(base_eff), .cur_i(cur), .addr_o(mem_req_addr_o));

    trio_lanes #(.LANES(LANES), .IDX_W(IDX_W)) i_lanes (
        .clk(clk), .rst(rst), .clr_i(lane_clr), .wr_i(lane_wr),
        .cur_i(cur), .data_i(mem_rsp_data_i), .vecs_o(vecs));

    assign dst0_o       = vecs[0];
    assign dst1_o       = vecs[1];
    assign dst2_o       = vecs[2];
    assign fault_elem_o = fault_lane[IDX_W-1:0];

    // R5: masked lanes are zero in every destination when done pulses
    for (genvar g = 0; g < LANES; g++) begin : g_zero_chk
        a_r5_masked_zero: assert property (@(posedge clk) disable iff (rst)
            (done_o && !pred_q[g]) |->
            (dst0_o[g*WORD_W +: WORD_W] == '0 && dst1_o[g*WORD_W +: WORD_W] == '0
             && dst2_o[g*WORD_W +: WORD_W] == '0));
    end
endmodule

// File: tb/test_trio_split_loader.sv
`timescale 1ns/1ps
module test_trio_split_loader;
    localparam int VLEN = 256;
    localparam int AW   = 32;
    localparam int NL   = VLEN / 64;
    localparam int IW   = $clog2(NL);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst, start_i, req_valid, req_ready, rsp_valid, rsp_err;
    logic [AW-1:0] base_i, index_i, req_addr;
    logic [NL-1:0] pred_i;
    logic [63:0]   rsp_data;
    logic [VLEN-1:0] dst0, dst1, dst2;
    logic          done_o, fault_o;
    logic [IW-1:0] fault_elem;

    trio_split_loader #(.VLEN(VLEN), .ADDR_W(AW)) i_trio_split_loader (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
        .index_i(index_i), .pred_i(pred_i),
        .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
        .mem_req_addr_o(req_addr), .mem_rsp_valid_i(rsp_valid),
        .mem_rsp_data_i(rsp_data), .mem_rsp_err_i(rsp_err),
        .dst0_o(dst0), .dst1_o(dst1), .dst2_o(dst2),
        .done_o(done_o), .fault_o(fault_o), .fault_elem_o(fault_elem));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model state
    bit          stall = 0, err_en = 0, tog = 0, pend = 0;
    logic [AW-1:0] err_addr = '0, paddr = '0;
    logic [AW-1:0] log_a [0:63];
    int          log_n = 0;
    int          last_rsp_cyc = 0;

    function automatic logic [63:0] memw(input logic [AW-1:0] a);
        return {a ^ 32'hC3D2_E1F0, ~a};
    endfunction

    function automatic logic [63:0] lane_of(input int j, input int i);
        case (j)
            0:       return dst0[64*i +: 64];
            1:       return dst1[64*i +: 64];
            default: return dst2[64*i +: 64];
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // responder: one outstanding read, answer in the cycle after acceptance
    initial begin
        req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_err   = 1'b0;
            if (pend) begin
                rsp_valid    = 1'b1;
                rsp_data     = memw(paddr);
                rsp_err      = err_en && (paddr == err_addr);
                pend         = 0;
                last_rsp_cyc = cyc;
            end
            req_ready = !stall || tog;
            tog = ~tog;
            if (req_valid && req_ready) begin
                if (log_n < 64) log_a[log_n] = req_addr;
                log_n++;
                pend  = 1;
                paddr = req_addr;
            end
        end
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog act=0 exp=1");
        summary();
        $finish;
    end

    // Runs one operation and checks requests, outputs and timing.
    task automatic op_run(input logic [AW-1:0] b, input logic [AW-1:0] ix,
                          input logic [NL-1:0] p, input bit st, input bit ee,
                          input logic [AW-1:0] ea, input bit hold_start);
        logic [AW-1:0] eb;
        logic [AW-1:0] ex [0:63];
        int nex = 0, fe = 0, n = 0;
        bit expf = 0, seen = 0;
        eb = b + (ix << 3);
        for (int i = 0; i < NL; i++)
            for (int j = 0; j < 3; j++)
                if (p[i] && !expf) begin
                    ex[nex] = eb + 24 * i + 8 * j;
                    nex++;
                    if (ee && ex[nex-1] == ea) begin expf = 1; fe = i; end
                end
        stall = st; err_en = ee; err_addr = ea; log_n = 0;
        @(negedge clk);
        start_i = 1'b1; base_i = b; index_i = ix; pred_i = p;
        while (!seen && n < 500) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (hold_start && n >= 2) begin
                start_i = 1'b1; base_i = 32'hDEAD_0000; pred_i = '1;
            end
            if (done_o || fault_o) begin seen = 1; start_i = 1'b0; end
        end
        chk(seen, "R6 operation ended", 64'(seen), 64'd1);
        chk(fault_o == expf, "R7 fault flag", 64'(fault_o), 64'(expf));
        chk(done_o == !expf, "R6 done flag", 64'(done_o), 64'(!expf));
        if (expf) chk(fault_elem == IW'(fe), "R7 fault lane", 64'(fault_elem), 64'(fe));
        chk(log_n == nex, "R4 request count", 64'(log_n), 64'(nex));
        for (int k = 0; k < nex && k < log_n; k++)
            chk(log_a[k] == ex[k], "R3 R1 request address order", 64'(log_a[k]), 64'(ex[k]));
        if (!expf)
            for (int i = 0; i < NL; i++)
                for (int j = 0; j < 3; j++) begin
                    if (p[i]) chk(lane_of(j, i) == memw(eb + 24 * i + 8 * j),
                                  "R2 lane data", lane_of(j, i), memw(eb + 24 * i + 8 * j));
                    else      chk(lane_of(j, i) == 64'd0, "R5 masked lane zero",
                                  lane_of(j, i), 64'd0);
                end
        if (!expf && p != '0)
            chk(cyc == last_rsp_cyc + 1, "R6 done timing", 64'(cyc), 64'(last_rsp_cyc + 1));
        if (p == '0) chk(n == 1, "R6 empty-mask done timing", 64'(n), 64'd1);
        @(negedge clk);
        chk(!done_o && !fault_o, "R6 single-cycle pulse", 64'({done_o, fault_o}), 64'd0);
        chk(!req_valid, "R9 idle after end", 64'(req_valid), 64'd0);
        if (hold_start) begin
            for (int k = 0; k < 4; k++) @(negedge clk);
            chk(log_n == nex && !req_valid && !done_o, "R8 busy strobe ignored",
                64'(log_n), 64'(nex));
        end
    endtask

    task automatic t_reset();
        chk(!req_valid && !done_o && !fault_o, "R10 reset controls",
            64'({req_valid, done_o, fault_o}), 64'd0);
        chk(dst0 == '0 && dst1 == '0 && dst2 == '0, "R10 reset vectors",
            64'(dst0 | dst1 | dst2), 64'd0);
    endtask

    task automatic t_full();       op_run(32'h0000_1000, 32'd0, 4'b1111, 0, 0, '0, 0); endtask
    task automatic t_sparse();     op_run(32'h0002_0040, 32'd5, 4'b0101, 1, 0, '0, 0); endtask
    task automatic t_rezero();
        op_run(32'h0003_0000, 32'd2, 4'b1111, 0, 0, '0, 0);
        op_run(32'h0003_0000, 32'd2, 4'b0010, 0, 0, '0, 0);  // R5 dirty lanes cleared
    endtask
    task automatic t_empty();      op_run(32'h0004_0000, 32'd1, 4'b0000, 0, 0, '0, 0); endtask
    task automatic t_fault();
        // lane 2, word 1 returns an error
        op_run(32'h0005_0000, 32'd0, 4'b1111, 0, 1, 32'h0005_0000 + 48 + 8, 0);
        op_run(32'h0005_0100, 32'd0, 4'b1001, 1, 0, '0, 0);   // R9 restart after fault
    endtask
    task automatic t_skip_bad();
        // lane 1 is masked; its first word would return an error (R4)
        op_run(32'h0006_0000, 32'd3, 4'b1101, 0, 1, 32'h0006_0018 + 24, 0);
    endtask
    task automatic t_busy();
        op_run(32'h0007_0000, 32'd1, 4'b0111, 1, 0, '0, 1);
        op_run(32'h0007_2000, 32'hFFFF_FFF0, 4'b1010, 0, 0, '0, 0); // R1 wrapping index
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; base_i = '0; index_i = '0; pred_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full();
        t_sparse();
        t_rezero();
        t_empty();
        t_fault();
        t_skip_bad();
        t_busy();
        summary();
        $finish;
    end
endmodule